// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block controls access to a small configuration fuse store through a command interface with a single strobe. A caller places a command code, an address and write data on the inputs and pulses the strobe while `ready` is high. The supported operations are: write a fuse word, read a fuse word back, force a value into the block's preload register, read a signature byte, write a signature byte, lock the device, and perform a full erase.

A lock bit guards the fuse contents. Once the lock bit is set, fuse readback and preload are refused from the very next access onward. A refused command returns zero data and raises `denied` for one cycle. An eight-byte user signature area is separate from the fuses and stays open for reads and writes whatever the lock state. It is meant for project name, revision or date bytes. The only way to clear the lock is a full erase, which also wipes the fuses, the signature and the preload register.

Fuse writes and erases hold `ready` low for a fixed busy window. Strobes that arrive during that window are dropped. Every command takes effect on the clock edge that accepts it. Read data appears one cycle later.

Top module: `cfg_access_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `ready` is 1, `rdata` is 0, `denied` is 0, `preload_q` is 0, every fuse word and signature byte is 0, and the lock is clear.
- R2: A command is accepted on a rising edge where `strobe` and `ready` are both 1. Code 1 writes `wdata` into fuse word `addr`. Code 2, while unlocked, returns fuse word `addr` on `rdata` in the cycle after acceptance.
- R3: After an accepted code 1 or code 7, `ready` is 0 for exactly BUSY_CYCLES cycles, starting in the next cycle. A strobe while `ready` is 0 is ignored: it changes no storage and no output. A strobe held into the cycle where `ready` returns is accepted.
- R4: Code 6 sets the lock, and the lock applies to the very next accepted command. While locked, code 2 returns `rdata` 0 and drives `denied` high for the one cycle after acceptance.
- R5: Code 3, while unlocked, loads `wdata` into `preload_q`. While locked, code 3 leaves `preload_q` unchanged and raises `denied` as in R4.
- R6: Code 5 writes `wdata` into signature byte `addr[2:0]`, and code 4 returns that byte on `rdata`. Both work with `denied` at 0 whether or not the lock is set.
- R7: Code 7 clears the lock, all fuse words, all signature bytes and `preload_q`.
- R8: Every accepted command other than an allowed code 2 or code 4 returns `rdata` 0. This includes code 0, which does nothing else. `denied` is 0 in every cycle that does not follow a refused command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code |
| addr | input | $clog2(FUSE_WORDS) | Fuse word address; low three bits select the signature byte |
| wdata | input | DATA_W | Write data |
| strobe | input | 1 | Command request |
| rdata | output | DATA_W | Read result, registered |
| ready | output | 1 | High when a command can be accepted |
| denied | output | 1 | One-cycle flag for a refused command |
| preload_q | output | DATA_W | Preload register contents |

## Verification
Two events can fall into the same cycle. The first pair is a strobe and the last busy cycle: the bench holds a strobe through a whole busy window and one cycle beyond it. The reference model must then see every strobe inside the window dropped and the final one accepted. The second pair is the lock command followed immediately by a readback: the bench issues the lock and a fuse read or preload on consecutive cycles and expects the second command to be refused. Every clock, the model's expected `rdata`, `denied`, `ready` and `preload_q` are compared against the design.

// File: rtl/cfg_acc_pkg.sv
package cfg_acc_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_PROGRAM = 3'd1,
        OP_VERIFY  = 3'd2,
        OP_PRELOAD = 3'd3,
        OP_SIG_RD  = 3'd4,
        OP_SIG_WR  = 3'd5,
        OP_SECURE  = 3'd6,
        OP_ERASE   = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } busy_st_e;
endpackage

// File: rtl/cfg_byte_bank.sv
module cfg_byte_bank #(
    parameter int WORDS = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [WORDS-1:0][W-1:0] mem;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (clr) begin
                mem[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cfg_busy_fsm.sv
module cfg_busy_fsm
    import cfg_acc_pkg::*;
#(
    parameter int CYCLES = 4,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    busy_st_e        state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ready   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                if (start) begin
                    state_d = ST_BUSY;
                    cnt_d   = CW'(CYCLES - 1);
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
    import cfg_acc_pkg::*;
#(
    parameter int FUSE_WORDS  = 16,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 4,
    localparam int AW         = $clog2(FUSE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              strobe,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              denied,
    output logic [DATA_W-1:0] preload_q
);
    localparam int SIG_BYTES = 8;
    localparam int SAW       = $clog2(SIG_BYTES);

    op_e               op;
    logic              accept;
    logic              sec_q;
    logic [DATA_W-1:0] fuse_rd, sig_rd;
    logic [DATA_W-1:0] rdata_d, preload_d;
    logic              deny_d, sec_d;
    logic              fuse_we, sig_we, wipe, busy_start;

    assign op     = op_e'(cmd);
    assign accept = strobe && ready;

    always_comb begin
        rdata_d    = '0;
        deny_d     = 1'b0;
        sec_d      = sec_q;
        preload_d  = preload_q;
        fuse_we    = 1'b0;
        sig_we     = 1'b0;
        wipe       = 1'b0;
        busy_start = 1'b0;
        if (accept) begin
            unique case (op)
                OP_NOP: ;
                OP_PROGRAM: begin
                    fuse_we    = 1'b1;
                    busy_start = 1'b1;
                end
                OP_VERIFY: begin
                    if (sec_q) deny_d  = 1'b1;
                    else       rdata_d = fuse_rd;
                end
                OP_PRELOAD: begin
                    if (sec_q) deny_d    = 1'b1;
                    else       preload_d = wdata;
                end
                OP_SIG_RD: rdata_d = sig_rd;
                OP_SIG_WR: sig_we  = 1'b1;
                OP_SECURE: sec_d   = 1'b1;
                OP_ERASE: begin
                    wipe       = 1'b1;
                    sec_d      = 1'b0;
                    preload_d  = '0;
                    busy_start = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q     <= 1'b0;
            rdata     <= '0;
            denied    <= 1'b0;
            preload_q <= '0;
        end else begin
            sec_q     <= sec_d;
            denied    <= deny_d;
            preload_q <= preload_d;
            if (accept) rdata <= rdata_d;
        end
    end

    cfg_byte_bank #(.WORDS(FUSE_WORDS), .W(DATA_W)) i_fuses (
        .clk(clk), .rst_n(rst_n), .clr(wipe), .we(fuse_we),
        .waddr(addr), .wdata(wdata), .raddr(addr), .rdata(fuse_rd)
    );

    cfg_byte_bank #(.WORDS(SIG_BYTES), .W(DATA_W)) i_sig (
        .clk(clk), .rst_n(rst_n), .clr(wipe), .we(sig_we),
        .waddr(addr[SAW-1:0]), .wdata(wdata), .raddr(addr[SAW-1:0]), .rdata(sig_rd)
    );

    cfg_busy_fsm #(.CYCLES(BUSY_CYCLES)) i_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .ready(ready)
    );
endmodule

// File: rtl/cfg_acc_checker.sv
module cfg_acc_checker
    import cfg_acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic              strobe,
    input logic              ready,
    input logic              denied,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] preload_q,
    input logic              sec
);
    logic go;
    assign go = strobe && ready;

    AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        denied |-> (rdata == '0)); // R4
    AST_BUSY_NO_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !denied); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(rdata) && $stable(preload_q))); // R3
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> ($past(strobe) && ($past(cmd) == 3'(OP_PROGRAM) || $past(cmd) == 3'(OP_ERASE)))); // R3
    AST_SEC_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sec && cmd == 3'(OP_VERIFY)) |=> denied); // R4
    AST_SEC_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sec && cmd == 3'(OP_PRELOAD)) |=> (denied && $stable(preload_q))); // R5
    AST_SIG_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (cmd == 3'(OP_SIG_RD) || cmd == 3'(OP_SIG_WR))) |=> !denied); // R6
    AST_ERASE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd == 3'(OP_ERASE)) |=> (!sec && preload_q == '0)); // R7
endmodule

bind cfg_access_ctrl cfg_acc_checker #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .strobe(strobe), .ready(ready),
    .denied(denied), .rdata(rdata), .preload_q(preload_q), .sec(sec_q)
);

// File: tb/test_cfg_access_ctrl.sv
module test_cfg_access_ctrl;
    localparam int CLK_PERIOD  = 10;
    localparam int FUSE_WORDS  = 16;
    localparam int DATA_W      = 8;
    localparam int BUSY_CYCLES = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd = '0;
    logic [3:0]        addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              strobe = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              ready;
    logic              denied;
    logic [DATA_W-1:0] preload_q;

    cfg_access_ctrl #(.FUSE_WORDS(FUSE_WORDS), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) i_cfg_access_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata), .strobe(strobe),
        .rdata(rdata), .ready(ready), .denied(denied), .preload_q(preload_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    mf[FUSE_WORDS];
    int    ms[8];
    bit    msec = 0;
    int    mbusy = 0;
    int    mrd = 0;
    int    mreg = 0;
    bit    mden = 0;
    string mtag = "R1";

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model: updates on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mf[i]) mf[i] = 0;
            foreach (ms[i]) ms[i] = 0;
            msec = 0; mbusy = 0; mrd = 0; mreg = 0; mden = 0; mtag = "R1";
        end else begin
            mden = 0;
            if (mbusy > 0) begin
                mbusy--;
            end else if (strobe) begin
                case (cmd)
                    3'd0: begin mrd = 0; mtag = "R8"; end
                    3'd1: begin mf[addr] = wdata; mrd = 0; mbusy = BUSY_CYCLES; mtag = "R2"; end
                    3'd2: if (msec) begin mrd = 0; mden = 1; mtag = "R4"; end
                          else begin mrd = mf[addr]; mtag = "R2"; end
                    3'd3: begin
                        mrd = 0; mtag = "R5";
                        if (msec) mden = 1; else mreg = wdata;
                    end
                    3'd4: begin mrd = ms[addr % 8]; mtag = "R6"; end
                    3'd5: begin ms[addr % 8] = wdata; mrd = 0; mtag = "R6"; end
                    3'd6: begin msec = 1; mrd = 0; mtag = "R4"; end
                    default: begin
                        foreach (mf[i]) mf[i] = 0;
                        foreach (ms[i]) ms[i] = 0;
                        msec = 0; mreg = 0; mrd = 0; mbusy = BUSY_CYCLES; mtag = "R7";
                    end
                endcase
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        chk(rdata == DATA_W'(mrd), mtag, "rdata", int'(rdata), mrd);
        chk(denied == mden, (mden ? mtag : "R8"), "denied", int'(denied), int'(mden));
        chk(ready == (mbusy == 0), (rst_n ? "R3" : "R1"), "ready", int'(ready), int'(mbusy == 0));
        chk(preload_q == DATA_W'(mreg), (rst_n ? "R5" : "R1"), "preload_q", int'(preload_q), mreg);
    end

    task automatic issue(int c, int a, int d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        cmd = 3'(c); addr = 4'(a); wdata = DATA_W'(d); strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; cmd = '0;
    endtask

    task automatic hold(int c, int a, int d, int n);
        cmd = 3'(c); addr = 4'(a); wdata = DATA_W'(d); strobe = 1'b1;
        repeat (n) @(negedge clk);
        strobe = 1'b0; cmd = '0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: program and read back every fuse word
        for (int i = 0; i < FUSE_WORDS; i++) issue(1, i, i * 13 + 5);
        for (int i = 0; i < FUSE_WORDS; i++) issue(2, i, 0);
        // R3: strobes inside a busy window are dropped, boundary strobe taken
        issue(1, 3, 8'hAA);
        hold(1, 3, 8'h55, BUSY_CYCLES);
        issue(2, 3, 0);
        issue(1, 4, 8'h11);
        hold(2, 4, 0, BUSY_CYCLES + 1);
        // R6: signature bytes, address wraps on low three bits
        for (int i = 0; i < 8; i++) issue(5, i, 8'hC0 + i);
        for (int i = 0; i < 8; i++) issue(4, i + 8, 0);
        // R5: preload while unlocked; R8: nop
        issue(3, 0, 8'h3C);
        issue(0, 0, 0);
        // R4: lock then readback on the very next cycle
        @(negedge clk);
        cmd = 3'd6; strobe = 1'b1;
        @(negedge clk);
        cmd = 3'd2; addr = 4'd5;
        @(negedge clk);
        cmd = 3'd3; wdata = 8'h99;
        @(negedge clk);
        cmd = 3'd2; addr = 4'd6;
        @(negedge clk);
        strobe = 1'b0;
        issue(4, 2, 0);
        issue(5, 2, 8'h77);
        issue(4, 2, 0);
        issue(1, 9, 8'hE1);
        issue(2, 9, 0);
        // R7: erase wipes everything and unlocks
        issue(7, 0, 0);
        issue(2, 9, 0);
        issue(2, 3, 0);
        issue(4, 2, 0);
        issue(3, 0, 8'h5A);
        issue(2, 0, 0);
        issue(0, 0, 0);
        repeat (3) @(negedge clk);
        report();
    end
endmodule